// File: doc/BRIEF.md
# One-Time-Program Fuse Controller

This block sequences the single permanent programming event of a digitally set resistor wiper. It models a small fuse bank: six data fuses that carry the wiper code, a test fuse used to check the setup, and a lock fuse that bars any further programming. The fuse state sits in sticky registers that the power-on reset does not clear. A power cycle can therefore be modelled by pulsing that reset. After each power-on the block picks the wiper source. A part that has not been programmed starts at the midscale code. A part that was programmed successfully starts at its fused code.

While the part is unprogrammed, wiper writes from the bus interface are accepted without limit. A write that carries the program flag starts a timed burn. The burn length is a parameter given in clock cycles. While the burn runs, a busy flag is raised and all writes are ignored. When the burn ends, the blown data fuses are compared against the code latched at the start. That comparison, together with the burn-success and test-fuse indications from an external fuse model, produces a sticky two-bit status. Only one burn may ever be attempted.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After a power-on pulse on a part that was never programmed, `wiper_code` is midscale (0x20 for 6 bits), `status` is 2'b00, `busy` is low and `wr_enable` is high.
- R2: While `wr_enable` is high, a write with `wr_prog`=0 loads `wr_code` into `wiper_code` on the next clock edge, for every code value.
- R3: A write with `wr_prog`=1 while `status` is 2'b00 and `busy` is low loads the code and raises `busy` on the next edge. `busy` then stays high for exactly BURN_CYCLES+1 clock cycles.
- R4: Writes and program requests that arrive while `busy` is high leave `wiper_code` unchanged and do not start another burn.
- R5: A burn ends with `status` 2'b11 if `test_ok` and `burn_ok` are both high and the blown data equals the latched code. The wiper then holds the programmed code.
- R6: A burn that ends with `test_ok` low gives `status` 2'b01.
- R7: A burn that ends with `test_ok` high but with `burn_ok` low, or with the blown data differing from the latched code, gives `status` 2'b10.
- R8: Once `status` is not 2'b00, it never changes again, and a program request never raises `busy`.
- R9: With `status` 2'b11, `wr_enable` is low and writes leave `wiper_code` unchanged.
- R10: A power-on pulse after a successful burn loads the fused code into `wiper_code` and keeps `status` at 2'b11.
- R11: A power-on pulse after a failed burn (status 2'b01 or 2'b10) keeps the status and presets `wiper_code` to midscale. Ordinary wiper writes are still accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset; does not clear fuses |
| wr_valid | input | 1 | Write strobe from the bus interface |
| wr_prog | input | 1 | Program flag carried with the write |
| wr_code | input | CODE_W | Wiper code carried with the write |
| burn_ok | input | 1 | Fuse model reports the data fuses blew correctly |
| test_ok | input | 1 | Fuse model reports the test fuse blew correctly |
| wiper_code | output | CODE_W | Effective wiper code |
| wr_enable | output | 1 | High when wiper writes are accepted |
| busy | output | 1 | High while a burn and its verify cycle run |
| status | output | 2 | Validation status: 00 ready, 01 test fail, 10 fatal, 11 programmed |

## Verification
Two functions can fall in the same cycle: an incoming bus write and the burn that is running. The bench provokes this by issuing both a plain write and a program request in the middle of the burn window. It judges the result by requiring the wiper to keep the latched code, requiring the busy window to keep exactly BURN_CYCLES+1 cycles, and requiring the final status to match the fuse-model inputs. A second overlap is a power-on pulse landing on a part that has already been programmed or has failed. For this case the bench checks the reloaded wiper code and the unchanged status on three parallel instances. The three instances are driven with the three outcomes of the fuse model.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    typedef enum logic [1:0] {
        ST_READY     = 2'b00,
        ST_TEST_FAIL = 2'b01,
        ST_FATAL     = 2'b10,
        ST_DONE      = 2'b11
    } otp_status_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_BURN   = 2'd1,
        SQ_VERIFY = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic attempted;
        logic test_blown;
        logic lock_blown;
        logic burn_fail;
    } fuse_flags_t;

    function automatic otp_status_e decode_status(input fuse_flags_t f);
        otp_status_e s;
        if (!f.attempted)       s = ST_READY;
        else if (!f.test_blown) s = ST_TEST_FAIL;
        else if (!f.lock_blown) s = ST_FATAL;
        else                    s = ST_DONE;
        return s;
    endfunction

endpackage

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
    import otp_fuse_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              por,
    input  logic              blow,
    input  logic [CODE_W-1:0] blow_code,
    input  logic              burn_ok,
    input  logic              commit,
    input  logic              test_ok,
    output logic [CODE_W-1:0] fused_code,
    output otp_status_e       status_o
);

    // Sticky fuse storage: power-on reset leaves it untouched.
    logic [CODE_W-1:0] data_q  = '0;
    fuse_flags_t       flags_q = '0;

    always_ff @(posedge clk) begin
        if (!por && blow) begin
            data_q            <= blow_code & {CODE_W{burn_ok}};
            flags_q.burn_fail <= !burn_ok;
        end
        if (!por && commit) begin
            flags_q.attempted  <= 1'b1;
            flags_q.test_blown <= test_ok;
            flags_q.lock_blown <= test_ok && !flags_q.burn_fail
                                  && (data_q == blow_code);
        end
    end

    assign fused_code = data_q;
    assign status_o   = decode_status(flags_q);

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (por)
        status_o != ST_READY |=> status_o == $past(status_o));

    a_r6_test_fail: assert property (@(posedge clk) disable iff (por)
        commit && !test_ok && status_o == ST_READY |=> status_o == ST_TEST_FAIL);

    a_r7_burn_fail: assert property (@(posedge clk) disable iff (por)
        commit && test_ok && flags_q.burn_fail && status_o == ST_READY
        |=> status_o == ST_FATAL);

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
    import otp_fuse_pkg::*;
#(
    parameter int BURN_CYCLES = 50_000_000
) (
    input  logic        clk,
    input  logic        por,
    input  logic        req,
    input  otp_status_e status_i,
    output logic        start,
    output logic        blow,
    output logic        commit,
    output logic        busy
);

    localparam int CNT_W = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURN_CYCLES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign start  = (state_q == SQ_IDLE) && req && (status_i == ST_READY);
    assign blow   = (state_q == SQ_BURN) && (cnt_q == LAST);
    assign commit = (state_q == SQ_VERIFY);
    assign busy   = (state_q != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= SQ_BURN;
                end
                SQ_BURN: begin
                    if (cnt_q == LAST) begin
                        state_q <= SQ_VERIFY;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_VERIFY: state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    a_r8_single_attempt: assert property (@(posedge clk) disable iff (por)
        status_i != ST_READY |-> !start);

    a_r3_busy_from_start: assert property (@(posedge clk) disable iff (por)
        $rose(busy) |-> $past(start));

    a_r3_verify_follows_blow: assert property (@(posedge clk) disable iff (por)
        blow |=> commit);

endmodule

// File: rtl/otp_wiper_reg.sv
module otp_wiper_reg
    import otp_fuse_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              accept,
    input  logic              lock_i,
    input  logic [CODE_W-1:0] fused_i,
    output logic [CODE_W-1:0] wiper_o
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] wiper_q;

    always_ff @(posedge clk) begin
        if (por)                      wiper_q <= lock_i ? fused_i : MID;
        else if (wr_valid && accept)  wiper_q <= wr_code;
    end

    assign wiper_o = wiper_q;

    a_r1_midscale_preset: assert property (@(posedge clk)
        por && !lock_i |=> wiper_o == MID);

    a_r4_hold_when_gated: assert property (@(posedge clk) disable iff (por)
        !accept |=> $stable(wiper_o));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int BURN_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wr_valid,
    input  logic              wr_prog,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              burn_ok,
    input  logic              test_ok,
    output logic [CODE_W-1:0] wiper_code,
    output logic              wr_enable,
    output logic              busy,
    output logic [1:0]        status
);

    otp_status_e       st;
    logic              start, blow, commit;
    logic [CODE_W-1:0] fused, code_q;

    always_ff @(posedge clk) begin
        if (por)        code_q <= '0;
        else if (start) code_q <= wr_code;
    end

    otp_burn_seq #(.BURN_CYCLES(BURN_CYCLES)) u_seq (
        .clk     (clk),
        .por     (por),
        .req     (wr_valid && wr_prog),
        .status_i(st),
        .start   (start),
        .blow    (blow),
        .commit  (commit),
        .busy    (busy)
    );

    otp_fuse_bank #(.CODE_W(CODE_W)) u_bank (
        .clk       (clk),
        .por       (por),
        .blow      (blow),
        .blow_code (code_q),
        .burn_ok   (burn_ok),
        .commit    (commit),
        .test_ok   (test_ok),
        .fused_code(fused),
        .status_o  (st)
    );

    assign wr_enable = !busy && (st != ST_DONE);

    otp_wiper_reg #(.CODE_W(CODE_W)) u_wiper (
        .clk     (clk),
        .por     (por),
        .wr_valid(wr_valid),
        .wr_code (wr_code),
        .accept  (wr_enable),
        .lock_i  (st == ST_DONE),
        .fused_i (fused),
        .wiper_o (wiper_code)
    );

    assign status = st;

    a_r10_reload_fused: assert property (@(posedge clk)
        por && st == ST_DONE |=> wiper_code == fused);

    a_r5_done_matches_latch: assert property (@(posedge clk) disable iff (por)
        commit && st == ST_READY |=> (st == ST_DONE) -> (fused == code_q));

    a_r9_locked_frozen: assert property (@(posedge clk) disable iff (por)
        st == ST_DONE |=> $stable(wiper_code));

endmodule

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;

    localparam int CODE_W = 6;
    localparam int BURN   = 20;
    localparam int MID    = 1 << (CODE_W - 1);

    logic clk = 1'b0;
    logic por = 1'b1;
    logic wr_valid = 1'b0, wr_prog = 1'b0;
    logic [CODE_W-1:0] wr_code = '0;

    logic [CODE_W-1:0] wp_a, wp_t, wp_b;
    logic en_a, en_t, en_b, bz_a, bz_t, bz_b;
    logic [1:0] st_a, st_t, st_b;

    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.CODE_W(CODE_W), .BURN_CYCLES(BURN)) uut (
        .clk(clk), .por(por), .wr_valid(wr_valid), .wr_prog(wr_prog), .wr_code(wr_code),
        .burn_ok(1'b1), .test_ok(1'b1),
        .wiper_code(wp_a), .wr_enable(en_a), .busy(bz_a), .status(st_a));

    otp_fuse_ctrl #(.CODE_W(CODE_W), .BURN_CYCLES(BURN)) uut_tfail (
        .clk(clk), .por(por), .wr_valid(wr_valid), .wr_prog(wr_prog), .wr_code(wr_code),
        .burn_ok(1'b1), .test_ok(1'b0),
        .wiper_code(wp_t), .wr_enable(en_t), .busy(bz_t), .status(st_t));

    otp_fuse_ctrl #(.CODE_W(CODE_W), .BURN_CYCLES(BURN)) uut_bfail (
        .clk(clk), .por(por), .wr_valid(wr_valid), .wr_prog(wr_prog), .wr_code(wr_code),
        .burn_ok(1'b0), .test_ok(1'b1),
        .wiper_code(wp_b), .wr_enable(en_b), .busy(bz_b), .status(st_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [CODE_W-1:0] c, input logic p);
        wr_valid = 1'b1; wr_prog = p; wr_code = c;
        tick();
        wr_valid = 1'b0; wr_prog = 1'b0;
    endtask

    task automatic power_cycle();
        por = 1'b1;
        tick(); tick();
        por = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        #1;
        tick(); tick(); tick();
        por = 1'b0;

        // R1: reset state on all three parts
        chk(wp_a == MID, "R1 wiper", wp_a, MID);
        chk(wp_t == MID && wp_b == MID, "R1 wiper others", wp_t, MID);
        chk(st_a == 2'b00 && st_t == 2'b00 && st_b == 2'b00, "R1 status", st_a, 0);
        chk(!bz_a && en_a, "R1 busy/enable", {bz_a, en_a}, 1);

        // R2: exhaustive code sweep while unprogrammed
        for (int c = 0; c < (1 << CODE_W); c++) begin
            write(CODE_W'(c), 1'b0);
            chk(wp_a == CODE_W'(c), "R2 write", wp_a, c);
        end
        for (int c = (1 << CODE_W) - 1; c >= 0; c -= 7) begin
            write(CODE_W'(c), 1'b0);
            chk(wp_t == CODE_W'(c) && wp_b == CODE_W'(c), "R2 write others", wp_t, c);
        end

        // R3: program request, count busy window; R4: collisions mid-burn
        write(6'h2A, 1'b1);
        chk(wp_a == 6'h2A, "R3 code loaded", wp_a, 6'h2A);
        n = 0;
        while (bz_a && n < 4 * BURN) begin
            n++;
            if (n == 5) begin
                wr_valid = 1'b1; wr_prog = 1'b0; wr_code = 6'h11;
            end else if (n == 9) begin
                wr_valid = 1'b1; wr_prog = 1'b1; wr_code = 6'h07;
            end else begin
                wr_valid = 1'b0; wr_prog = 1'b0;
            end
            tick();
            if (bz_a) chk(wp_a == 6'h2A, "R4 wiper held during burn", wp_a, 6'h2A);
            if (bz_a) chk(!en_a, "R4 enable low during burn", en_a, 0);
        end
        wr_valid = 1'b0; wr_prog = 1'b0;
        chk(n == BURN + 1, "R3 busy length", n, BURN + 1);
        tick();
        chk(!bz_a, "R4 no restart after collision", bz_a, 0);

        // R5, R6, R7: outcomes
        chk(st_a == 2'b11, "R5 status", st_a, 3);
        chk(wp_a == 6'h2A, "R5 wiper", wp_a, 6'h2A);
        chk(st_t == 2'b01, "R6 status", st_t, 1);
        chk(st_b == 2'b10, "R7 status", st_b, 2);

        // R8: second attempt refused everywhere
        write(6'h15, 1'b1);
        chk(!bz_a && !bz_t && !bz_b, "R8 no second burn", {bz_a, bz_t, bz_b}, 0);
        tick();
        chk(!bz_a && !bz_t && !bz_b, "R8 still idle", {bz_a, bz_t, bz_b}, 0);
        chk(st_a == 2'b11 && st_t == 2'b01 && st_b == 2'b10, "R8 status kept",
            {st_a, st_t, st_b}, 6'b110110);

        // R9: locked part ignores writes
        chk(!en_a, "R9 enable low", en_a, 0);
        write(6'h05, 1'b0);
        chk(wp_a == 6'h2A, "R9 wiper frozen", wp_a, 6'h2A);
        chk(wp_t == 6'h05 && wp_b == 6'h05, "R11 failed parts still adjust", wp_t, 5);

        // R10, R11: power cycles
        for (int k = 0; k < 2; k++) begin
            power_cycle();
            chk(wp_a == 6'h2A, "R10 fused reload", wp_a, 6'h2A);
            chk(st_a == 2'b11, "R10 status kept", st_a, 3);
            chk(wp_t == MID && wp_b == MID, "R11 midscale after failure", wp_t, MID);
            chk(st_t == 2'b01 && st_b == 2'b10, "R11 status kept", {st_t, st_b}, 4'b0110);
            write(6'h3F, 1'b1);
            chk(!bz_a && !bz_t && !bz_b, "R8 refused after power cycle",
                {bz_a, bz_t, bz_b}, 0);
            chk(wp_a == 6'h2A && wp_t == 6'h3F, "R9 R11 write after power cycle", wp_a, 6'h2A);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule